// File: doc/BRIEF.md
# Data Object Exchange Mailbox Responder

This block is the device side of a data object mailbox that sits behind a dword register port. The host builds a request by writing dwords one at a time into the write-mailbox register. The first dword is header 1, holding a 16-bit vendor ID in bits 15:0 and an object type in bits 23:16. The second dword is header 2, holding the total object length in dwords in bits 17:0; that length includes both header dwords. The host then sets the Go bit in the control register. The block spends a fixed number of cycles preparing a response, with Busy set during that time. It then presents the response object through the read-mailbox register, with Data Object Ready set. Busy raises no interrupt when it clears, so the host must poll for it.

The response is an echo. Header 1 is returned unchanged. Header 2 returns the same Length field. Each payload dword k is the first request payload dword plus k. Because the payload is generated rather than stored, no object buffer is needed, and the largest object size is supported. A Length field of zero stands for 2^18 dwords. Reading the read mailbox returns the current dword, and any write to it acknowledges that dword and moves to the next. An Abort bit in the control register puts the mailbox back to idle.

The register offsets are: control at 0x08 (Abort bit 0, Go bit 31), status at 0x0C (Busy bit 0, Error bit 2, Ready bit 31), write mailbox at 0x10, and read mailbox at 0x14. Any other address reads as zero.

Top module: `doe_responder`

## Requirements
- R1: After reset the status register (0x0C) reads zero and the read mailbox (0x14) reads zero.
- R2: A Go (control bit 31) issued with a complete, well-formed header sets Busy (status bit 0) from the next cycle for exactly STAGE_CYC cycles. When Busy clears, Ready (status bit 31) is set.
- R3: While Ready is set, the read mailbox returns, in order: header 1 unchanged, then header 2 with the request's Length in bits 17:0 and zeros above, then payload dword k equal to the first request payload dword plus k (modulo 2^32). Further request payload dwords have no effect on the response.
- R4: Each write to the read mailbox while Ready is set advances to the next dword. The write that acknowledges the last dword (index decoded length minus 1) clears Ready.
- R5: While Ready is clear, the read mailbox reads zero and writes to it are ignored. A later object still starts at header 1.
- R6: A Length field of zero encodes 2^18 dwords. Header 2 is echoed as zero, and Ready stays set across many acknowledged dwords.
- R7: Go with Length field 1, or with fewer than two dwords written since the last object was taken, sets Error (status bit 2) and sets neither Busy nor Ready.
- R8: A write to the write mailbox while Busy is set is ignored and sets Error. The staged response is the one from the request as it stood before that write.
- R9: Error stays set until Abort, and Go is ignored while Error is set.
- R10: Abort (control bit 0) clears Busy, Ready, Error and any partly written request, whether it arrives during staging or during response reading.
- R11: A control write with both Abort and Go set acts as Abort alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register being accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The embedded assertions check these rules on every cycle:
- A write to the write mailbox during staging sets Error.
- Error persists until Abort.
- Abort returns the control state to idle.
- A malformed Go produces Error without Busy.
- Busy always hands over to Ready unless Abort intervened.
- The read mailbox reads zero whenever no object is ready.

Only the bench's scenarios can show that the dword sequence is correct for every length, that the staging window lasts exactly STAGE_CYC cycles, that acknowledged pops end the object at the right dword, and that a zero Length keeps the object open far beyond the short lengths.

// File: rtl/doe_pkg.sv
package doe_pkg;
    localparam int unsigned LEN_W = 18;
    localparam int unsigned TOT_W = LEN_W + 1;

    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_WMB  = 8'h10;
    localparam logic [7:0] OFS_RMB  = 8'h14;

    localparam int unsigned CTL_ABORT_BIT = 0;
    localparam int unsigned CTL_GO_BIT    = 31;

    typedef enum logic [1:0] {
        MB_IDLE  = 2'd0,
        MB_STAGE = 2'd1,
        MB_SEND  = 2'd2
    } mb_state_e;
endpackage

// File: rtl/doe_req_rx.sv
module doe_req_rx
    import doe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      hdr1_o,
    output logic [LEN_W-1:0] len_o,
    output logic [31:0]      seed_o,
    output logic [1:0]       cnt_o
);
    typedef struct packed {
        logic [1:0]       cnt;
        logic [31:0]      hdr1;
        logic [LEN_W-1:0] len;
        logic [31:0]      seed;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (clear_i) begin
            rx_d = '0;
        end else if (push_i) begin
            case (rx_q.cnt)
                2'd0:    rx_d.hdr1 = wdata_i;
                2'd1:    rx_d.len  = wdata_i[LEN_W-1:0];
                2'd2:    rx_d.seed = wdata_i;
                default: ;
            endcase
            if (rx_q.cnt != 2'd3) rx_d.cnt = rx_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign hdr1_o = rx_q.hdr1;
    assign len_o  = rx_q.len;
    assign seed_o = rx_q.seed;
    assign cnt_o  = rx_q.cnt;
endmodule

// File: rtl/doe_ctrl.sv
module doe_ctrl
    import doe_pkg::*;
#(
    parameter int unsigned STAGE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic abort_i,
    input  logic wmb_wr_i,
    input  logic hdr_ok_i,
    input  logic pop_i,
    input  logic last_i,
    output logic busy_o,
    output logic ready_o,
    output logic err_o,
    output logic load_o,
    output logic clear_o,
    output logic push_o
);
    localparam int unsigned SC_W = (STAGE_CYC < 2) ? 1 : $clog2(STAGE_CYC);

    typedef struct packed {
        mb_state_e       state;
        logic [SC_W-1:0] stg;
        logic            err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        load_o  = 1'b0;
        clear_o = 1'b0;
        push_o  = 1'b0;
        if (abort_i) begin
            ctl_d.state = MB_IDLE;
            ctl_d.stg   = '0;
            ctl_d.err   = 1'b0;
            clear_o     = 1'b1;
        end else begin
            if (wmb_wr_i) begin
                if (ctl_q.state == MB_STAGE) ctl_d.err = 1'b1;
                else                         push_o    = 1'b1;
            end
            case (ctl_q.state)
                MB_IDLE: begin
                    if (go_i && !ctl_q.err) begin
                        if (hdr_ok_i) begin
                            ctl_d.state = MB_STAGE;
                            ctl_d.stg   = SC_W'(STAGE_CYC - 1);
                        end else begin
                            ctl_d.err = 1'b1;
                            clear_o   = 1'b1;
                        end
                    end
                end
                MB_STAGE: begin
                    if (ctl_q.stg == '0) begin
                        ctl_d.state = MB_SEND;
                        load_o      = 1'b1;
                        clear_o     = 1'b1;
                    end else begin
                        ctl_d.stg = ctl_q.stg - SC_W'(1);
                    end
                end
                MB_SEND: begin
                    if (pop_i && last_i) ctl_d.state = MB_IDLE;
                end
                default: ctl_d.state = MB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= MB_IDLE;
            ctl_q.stg   <= '0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o  = (ctl_q.state == MB_STAGE);
    assign ready_o = (ctl_q.state == MB_SEND);
    assign err_o   = ctl_q.err;

    // R8
    wmb_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wmb_wr_i && busy_o && !abort_i) |=> err_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !abort_i) |=> err_o);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !ready_o && !err_o));

    // R7
    bad_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !abort_i && !busy_o && !ready_o && !err_o && !hdr_ok_i) |=> (err_o && !busy_o && !ready_o));

    // R2
    busy_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !abort_i) |=> (busy_o || ready_o));
endmodule

// File: rtl/doe_resp_tx.sv
module doe_resp_tx
    import doe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             abort_i,
    input  logic             pop_i,
    input  logic [31:0]      hdr1_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [31:0]      seed_i,
    output logic [31:0]      dword_o,
    output logic             last_o
);
    typedef struct packed {
        logic [TOT_W-1:0] idx;
        logic [31:0]      hdr1;
        logic [LEN_W-1:0] len;
        logic [31:0]      seed;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [TOT_W-1:0] total;

    always_comb begin
        total  = (tx_q.len == '0) ? (TOT_W'(1) << LEN_W) : {1'b0, tx_q.len};
        last_o = (tx_q.idx == total - TOT_W'(1));
        if (tx_q.idx == '0)
            dword_o = tx_q.hdr1;
        else if (tx_q.idx == TOT_W'(1))
            dword_o = 32'(tx_q.len);
        else
            dword_o = tx_q.seed + 32'(tx_q.idx - TOT_W'(2));
    end

    always_comb begin
        tx_d = tx_q;
        if (abort_i) begin
            tx_d = '0;
        end else if (load_i) begin
            tx_d.idx  = '0;
            tx_d.hdr1 = hdr1_i;
            tx_d.len  = len_i;
            tx_d.seed = seed_i;
        end else if (pop_i) begin
            tx_d.idx = tx_q.idx + TOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end
endmodule

// File: rtl/doe_responder.sv
module doe_responder
    import doe_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned STAGE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    logic sel_ctrl, sel_stat, sel_wmb, sel_rmb;
    logic go, abort, wmb_wr, pop, hdr_ok;
    logic busy, ready, err, load, clear, push, last;
    logic [31:0]      rx_hdr1, rx_seed, tx_dword;
    logic [LEN_W-1:0] rx_len;
    logic [1:0]       rx_cnt;

    assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign sel_wmb  = (reg_addr == ADDR_W'(OFS_WMB));
    assign sel_rmb  = (reg_addr == ADDR_W'(OFS_RMB));

    assign abort  = reg_wr && sel_ctrl && reg_wdata[CTL_ABORT_BIT];
    assign go     = reg_wr && sel_ctrl && reg_wdata[CTL_GO_BIT];
    assign wmb_wr = reg_wr && sel_wmb;
    assign pop    = reg_wr && sel_rmb && ready;
    assign hdr_ok = (rx_cnt >= 2'd2) && (rx_len != LEN_W'(1));

    doe_req_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .push_i  (push),
        .wdata_i (reg_wdata),
        .hdr1_o  (rx_hdr1),
        .len_o   (rx_len),
        .seed_o  (rx_seed),
        .cnt_o   (rx_cnt)
    );

    doe_ctrl #(.STAGE_CYC(STAGE_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .abort_i  (abort),
        .wmb_wr_i (wmb_wr),
        .hdr_ok_i (hdr_ok),
        .pop_i    (pop),
        .last_i   (last),
        .busy_o   (busy),
        .ready_o  (ready),
        .err_o    (err),
        .load_o   (load),
        .clear_o  (clear),
        .push_o   (push)
    );

    doe_resp_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .abort_i (abort),
        .pop_i   (pop),
        .hdr1_i  (rx_hdr1),
        .len_i   (rx_len),
        .seed_i  (rx_seed),
        .dword_o (tx_dword),
        .last_o  (last)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_stat)
            reg_rdata = {ready, 28'd0, err, 1'b0, busy};
        else if (sel_rmb && ready)
            reg_rdata = tx_dword;
    end

    // R5
    rmb_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rmb && !ready) |-> (reg_rdata == 32'd0));

    // R4
    last_pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && last && !abort) |=> !ready);
endmodule

// File: tb/doe_responder_tb.sv
module doe_responder_tb;
    localparam int unsigned STAGE = 4;
    localparam logic [7:0] A_CTRL = 8'h08, A_STAT = 8'h0C, A_WMB = 8'h10, A_RMB = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    doe_responder #(.ADDR_W(8), .STAGE_CYC(STAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_req(input logic [31:0] h1, input logic [31:0] h2,
                            input int unsigned npay, input logic [31:0] seed);
        wr(A_WMB, h1);
        wr(A_WMB, h2);
        for (int j = 0; j < int'(npay); j++)
            wr(A_WMB, (j == 0) ? seed : (seed ^ 32'h5A5A0000 ^ 32'(j)));
    endtask

    task automatic go_and_wait(input string req);
        logic [31:0] s;
        int n;
        wr(A_CTRL, 32'h8000_0000);
        n = 0;
        rd(A_STAT, s);
        while (s[0] && n < 100) begin
            n++;
            @(negedge clk);
            rd(A_STAT, s);
        end
        chk(req, 32'(n), 32'(STAGE));
        chk(req, s, 32'h8000_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h1, seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 32'd0);
        rd(A_RMB, v);  chk("R1 rmb", v, 32'd0);

        // R5 pop while idle is ignored, then object starts at header 1
        wr(A_RMB, 32'd0);
        rd(A_RMB, v); chk("R5 idle read", v, 32'd0);

        // R2 R3 R4 sweep over lengths and patterns
        for (int len = 2; len <= 9; len++) begin
            for (int p = 0; p < 3; p++) begin
                h1 = {8'h00, 8'(8'h10 + p * 7 + len), 16'(16'h1E00 + len * 3 + p)};
                seed = 32'hFFFF_FFFD + 32'(p * 32'h0111_0000) + 32'(len);
                send_req(h1, 32'(len), (p == 2) ? 0 : len - 2, seed);
                if (p == 2) seed = 32'd0;
                go_and_wait("R2 busy window");
                for (int k = 0; k < len; k++) begin
                    rd(A_RMB, v);
                    if (k == 0)      chk("R3 header1", v, h1);
                    else if (k == 1) chk("R3 header2", v, 32'(len));
                    else             chk("R3 payload", v, seed + 32'(k - 2));
                    rd(A_STAT, v);
                    chk("R4 ready held", v, 32'h8000_0000);
                    wr(A_RMB, 32'd0);
                end
                rd(A_STAT, v); chk("R4 ready cleared", v, 32'd0);
                rd(A_RMB, v);  chk("R5 rmb zero after", v, 32'd0);
            end
        end

        // R6 zero length means 2^18 dwords
        send_req(32'h0003_0001, 32'h0000_0000, 1, 32'hABCD_0000);
        go_and_wait("R6 busy window");
        rd(A_RMB, v); chk("R6 header1", v, 32'h0003_0001); wr(A_RMB, 0);
        rd(A_RMB, v); chk("R6 header2 zero", v, 32'd0);    wr(A_RMB, 0);
        for (int k = 0; k < 40; k++) begin
            rd(A_RMB, v); chk("R6 payload", v, 32'hABCD_0000 + 32'(k));
            wr(A_RMB, 0);
        end
        rd(A_STAT, v); chk("R6 still ready", v, 32'h8000_0000);
        // R10 abort during reading
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R10 abort mid-read", v, 32'd0);
        rd(A_RMB, v);  chk("R10 rmb after abort", v, 32'd0);

        // R7 Length field 1
        send_req(32'h0001_0001, 32'h0000_0001, 0, 0);
        wr(A_CTRL, 32'h8000_0000);
        rd(A_STAT, v); chk("R7 len1 error", v, 32'h4);
        wr(A_CTRL, 32'h1);
        // R7 only one dword written
        wr(A_WMB, 32'h0001_0001);
        wr(A_CTRL, 32'h8000_0000);
        rd(A_STAT, v); chk("R7 short header error", v, 32'h4);
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R9 abort clears error", v, 32'd0);

        // R8 write during Busy ignored and sets Error
        send_req(32'h0022_0044, 32'd4, 2, 32'h1000_0000);
        wr(A_CTRL, 32'h8000_0000);
        wr(A_WMB, 32'hDEAD_BEEF);
        repeat (STAGE + 2) @(negedge clk);
        rd(A_STAT, v); chk("R8 error with ready", v, 32'h8000_0004);
        rd(A_RMB, v); chk("R8 header1 intact", v, 32'h0022_0044); wr(A_RMB, 0);
        rd(A_RMB, v); chk("R8 header2 intact", v, 32'd4);          wr(A_RMB, 0);
        rd(A_RMB, v); chk("R8 payload0 intact", v, 32'h1000_0000); wr(A_RMB, 0);
        rd(A_RMB, v); chk("R8 payload1 intact", v, 32'h1000_0001); wr(A_RMB, 0);
        // R9 error sticky, Go ignored
        rd(A_STAT, v); chk("R9 error sticky", v, 32'h4);
        send_req(32'h0022_0044, 32'd3, 1, 32'h7);
        wr(A_CTRL, 32'h8000_0000);
        rd(A_STAT, v); chk("R9 go ignored", v, 32'h4);
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R10 abort clears", v, 32'd0);

        // R10 abort during staging, and request capture cleared
        send_req(32'h0055_0066, 32'd3, 1, 32'h9);
        wr(A_CTRL, 32'h8000_0000);
        rd(A_STAT, v); chk("R2 busy after go", v, 32'h1);
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R10 abort mid-stage", v, 32'd0);
        repeat (STAGE + 2) @(negedge clk);
        rd(A_STAT, v); chk("R10 no late ready", v, 32'd0);
        wr(A_CTRL, 32'h8000_0000);
        rd(A_STAT, v); chk("R10 request cleared", v, 32'h4);
        wr(A_CTRL, 32'h1);

        // R11 abort and go together
        send_req(32'h0077_0088, 32'd2, 0, 0);
        wr(A_CTRL, 32'h8000_0001);
        rd(A_STAT, v); chk("R11 abort wins", v, 32'd0);
        wr(A_CTRL, 32'h8000_0000);
        rd(A_STAT, v); chk("R11 request dropped", v, 32'h4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule